// File: doc/BRIEF.md
# Dynamically Controlled 64-bit Accumulator

This block is the final add stage of an arithmetic datapath. Each cycle it takes a signed 64-bit input word and three control bits (negate, load-constant, accumulate), and it writes a 64-bit registered result. The control bits change from cycle to cycle and choose the operation:

- **Pass-through.** The input alone is registered.
- **Running sum.** The input is added to the stored result.
- **Running difference.** The input is negated in two's complement and then added to the stored result.
- **Preload.** A constant with exactly one bit set is added to the input in place of the stored result. This gives a rounding offset at a chosen bit position.

A wider datapath uses the block as follows. It asserts load-constant on the first term of a sum, so the rounding offset is added at that term. It then holds accumulate high, or negate and accumulate high together, for the remaining terms. The clock enable lets the datapath stall the result. A synchronous reset clears it.

Top module: `dyn_accumulator`

## Requirements
- R1: All additions are 64 bits wide and wrap modulo 2^64, with no saturation. For example, all-ones plus 1 gives 0.
- R2: When {neg,load,acc} = 3'b000, the next result equals `din`. The stored result is not used.
- R3: When {neg,load,acc} = 3'b001, the next result equals the previous result plus `din`.
- R4: When {neg,load,acc} = 3'b101, the next result equals the previous result plus the two's complement of `din`, which is the previous result minus `din`.
- R5: When {neg,load,acc} = 3'b010, the next result equals `din` plus the preload constant 2^`pre_pos`. The stored result is not used.
- R6: The combinations 3'b011, 3'b100, 3'b110 and 3'b111 behave exactly like 3'b000.
- R7: While `en` is low and `rst` is low, `result` keeps its value, whatever the other inputs are.
- R8: A synchronous reset sets `result` to 0 on the next rising edge. Reset takes priority over `en` and over the control bits.
- R9: The preload constant has exactly one bit set, at bit index `pre_pos`, where index 0 is the LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the result register |
| din | input | 64 | Signed input word |
| ctl_neg | input | 1 | Negate control bit |
| ctl_load | input | 1 | Load-constant control bit |
| ctl_acc | input | 1 | Accumulate control bit |
| pre_pos | input | 6 | Bit index of the preload constant |
| result | output | 64 | Registered 64-bit result |

## Verification
The bench targets these corner cases:

- **Carry wrap at the top bit.** A design that saturated, or that added at the wrong width, would not return 0 after all-ones plus 1.
- **Difference from zero.** A design that negated with one's complement, or that dropped the +1, would be off by one from all-ones.
- **Preload at bit indices 0 and 63.** A shift that was off by one or truncated would show at one of the two ends.
- **The four unlisted control codes.** A decoder that fed back the stored result for any of them would fail.
- **Reset asserted with enable low, and stalls in the middle of a sum.** These expose an enable that wrongly gates reset, or a register that updates while stalled.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [1:0] {
    MODE_ZERO = 2'd0,
    MODE_ACC  = 2'd1,
    MODE_DEC  = 2'd2,
    MODE_PRE  = 2'd3
  } acc_mode_e;

  // Map the three control bits {neg,load,acc} to an operating mode.
  // Any code outside the four defined ones falls back to pass-through.
  function automatic acc_mode_e decode_ctl(input logic neg, input logic load, input logic acc);
    case ({neg, load, acc})
      3'b001:  return MODE_ACC;
      3'b101:  return MODE_DEC;
      3'b010:  return MODE_PRE;
      default: return MODE_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/acc_mode_decode.sv
module acc_mode_decode
  import acc_pkg::*;
(
  input  logic      neg,
  input  logic      load,
  input  logic      acc,
  output acc_mode_e mode,
  output logic      use_fb,
  output logic      use_pre,
  output logic      do_neg
);
  always_comb begin
    mode    = decode_ctl(neg, load, acc);
    use_fb  = (mode == MODE_ACC) || (mode == MODE_DEC);
    use_pre = (mode == MODE_PRE);
    do_neg  = (mode == MODE_DEC);
  end
endmodule

// File: rtl/acc_preload_gen.sv
module acc_preload_gen #(
  parameter int WIDTH = 64,
  localparam int POS_W = $clog2(WIDTH)
) (
  input  logic [POS_W-1:0] pos,
  output logic [WIDTH-1:0] const_word
);
  // One comparator per bit. At most one comparator can match.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign const_word[b] = (pos == POS_W'(b));
  end
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] base,
  input  logic [WIDTH-1:0] addend,
  input  logic             negate,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] operand;

  always_comb begin
    // Two's complement: invert the bits, then add one. The sum wraps modulo 2^WIDTH.
    operand = negate ? (~addend + WIDTH'(1)) : addend;
    sum     = base + operand;
  end
endmodule

// File: rtl/dyn_accumulator.sv
module dyn_accumulator
  import acc_pkg::*;
#(
  parameter int WIDTH = 64,
  localparam int POS_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  input  logic             ctl_neg,
  input  logic             ctl_load,
  input  logic             ctl_acc,
  input  logic [POS_W-1:0] pre_pos,
  output logic [WIDTH-1:0] result
);
  acc_mode_e        mode;
  logic             use_fb;
  logic             use_pre;
  logic             do_neg;
  logic [WIDTH-1:0] pre_const;
  logic [WIDTH-1:0] base_sel;
  logic [WIDTH-1:0] next_val;

  acc_mode_decode i_dec (
    .neg(ctl_neg), .load(ctl_load), .acc(ctl_acc),
    .mode(mode), .use_fb(use_fb), .use_pre(use_pre), .do_neg(do_neg)
  );

  acc_preload_gen #(.WIDTH(WIDTH)) i_pre (
    .pos(pre_pos), .const_word(pre_const)
  );

  // The adder's base input is the stored result (sum or difference),
  // the preload constant (preload), or zero (pass-through).
  always_comb begin
    if (use_fb)       base_sel = result;
    else if (use_pre) base_sel = pre_const;
    else              base_sel = '0;
  end

  acc_adder #(.WIDTH(WIDTH)) i_add (
    .base(base_sel), .addend(din), .negate(do_neg), .sum(next_val)
  );

  always_ff @(posedge clk) begin
    if (rst)     result <= '0;
    else if (en) result <= next_val;
  end
endmodule

// File: rtl/acc_checker.sv
module acc_checker
  import acc_pkg::*;
#(
  parameter int WIDTH = 64,
  localparam int POS_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] din,
  input logic [POS_W-1:0] pre_pos,
  input acc_mode_e        mode,
  input logic             use_fb,
  input logic             use_pre,
  input logic             do_neg,
  input logic [WIDTH-1:0] pre_const,
  input logic [WIDTH-1:0] result
);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(result));

  a_r8_reset: assert property (@(posedge clk)
    rst |=> (result == '0));

  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    ($countones(pre_const) == 1) && pre_const[pre_pos]);

  a_r6_flags: assert property (@(posedge clk) disable iff (rst)
    $onehot0({use_fb, use_pre}) && (!do_neg || use_fb));

  a_r3_acc: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_ACC) |=> (result == $past(result) + $past(din)));

  a_r4_dec: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_DEC) |=> (result == $past(result) - $past(din)));

  a_r2_zero: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_ZERO) |=> (result == $past(din)));
endmodule

bind dyn_accumulator acc_checker #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rst(rst), .en(en), .din(din), .pre_pos(pre_pos),
  .mode(mode), .use_fb(use_fb), .use_pre(use_pre), .do_neg(do_neg),
  .pre_const(pre_const), .result(result)
);

// File: tb/test_dyn_accumulator.sv
module test_dyn_accumulator;
  logic        clk = 1'b0;
  logic        rst, en, neg, load, acc;
  logic [63:0] din;
  logic [5:0]  pos;
  logic [63:0] result;
  logic [63:0] model;
  int          n_run = 0, n_fail = 0;

  dyn_accumulator i_dyn_accumulator (
    .clk(clk), .rst(rst), .en(en), .din(din), .ctl_neg(neg),
    .ctl_load(load), .ctl_acc(acc), .pre_pos(pos), .result(result)
  );

  always #10 clk = ~clk;

  // Expected next result, written from the requirement list.
  function automatic logic [63:0] expect_next(
    input logic [63:0] prev, input logic [2:0] code,
    input logic [63:0] d, input logic [5:0] p);
    logic [63:0] one_bit;
    one_bit = 64'd1 << p;
    if (code == 3'b001)      return prev + d;           // R3
    else if (code == 3'b101) return prev + (~d + 64'd1); // R4
    else if (code == 3'b010) return d + one_bit;        // R5, R9
    else                     return d;                  // R2, R6
  endfunction

  task automatic check(input string req, input logic [63:0] exp);
    n_run++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, result, exp);
    end
  endtask

  // Apply one set of inputs on the falling edge, let one rising edge pass,
  // then compare away from the edge.
  task automatic step(input string req, input logic r, input logic e,
                      input logic [2:0] code, input logic [63:0] d, input logic [5:0] p);
    @(negedge clk);
    rst = r; en = e; {neg, load, acc} = code; din = d; pos = p;
    if (r)      model = 64'd0;
    else if (e) model = expect_next(model, code, d, p);
    @(posedge clk);
    #2;
    check(req, model);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; en = 1'b0; {neg, load, acc} = 3'b000; din = '0; pos = '0; model = '0;

    step("R8 reset", 1'b1, 1'b1, 3'b001, 64'hdead, 6'd0);
    step("R8 reset with en low", 1'b1, 1'b0, 3'b000, 64'h5, 6'd0);
    step("R2 zero", 1'b0, 1'b1, 3'b000, 64'h1234_5678_9abc_def0, 6'd0);
    step("R3 acc", 1'b0, 1'b1, 3'b001, 64'h10, 6'd0);
    step("R7 hold", 1'b0, 1'b0, 3'b000, 64'hffff, 6'd3);
    step("R7 hold acc", 1'b0, 1'b0, 3'b001, 64'h1, 6'd3);
    step("R1 load ones", 1'b0, 1'b1, 3'b000, 64'hffff_ffff_ffff_ffff, 6'd0);
    step("R1 wrap", 1'b0, 1'b1, 3'b001, 64'd1, 6'd0);
    step("R4 dec from zero", 1'b0, 1'b1, 3'b101, 64'd1, 6'd0);
    step("R4 dec", 1'b0, 1'b1, 3'b101, 64'h100, 6'd0);
    step("R5 R9 preload pos0", 1'b0, 1'b1, 3'b010, 64'd0, 6'd0);
    step("R5 R9 preload pos63", 1'b0, 1'b1, 3'b010, 64'd0, 6'd63);
    step("R5 preload plus din", 1'b0, 1'b1, 3'b010, 64'h7, 6'd4);
    step("R6 code 011", 1'b0, 1'b1, 3'b011, 64'haa, 6'd2);
    step("R6 code 100", 1'b0, 1'b1, 3'b100, 64'hbb, 6'd2);
    step("R6 code 110", 1'b0, 1'b1, 3'b110, 64'hcc, 6'd2);
    step("R6 code 111", 1'b0, 1'b1, 3'b111, 64'hdd, 6'd2);
    step("R8 reset mid sum", 1'b1, 1'b0, 3'b001, 64'h9, 6'd0);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] c;
      logic r, e;
      c = 3'($urandom);
      if (($urandom % 3) != 0) c = ($urandom % 2) ? 3'b001 : 3'b101;
      r = (($urandom % 50) == 0);
      e = (($urandom % 6) != 0);
      step("R1 R3 R4 random", r, e, c, {$urandom, $urandom}, 6'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule